// File: doc/BRIEF.md
# Dual-Rail Taint Tracker with Redundancy Voter

This block evaluates a small fixed Boolean function, an AND-OR-invert over pairs of inputs, in two forms at once. The plain form works on ordinary data bits. The tracking form carries every input as a pair of rails, `{hi, lo}`, in a three-symbol code: a trusted zero, a trusted one, or an untrusted value whose data is a don't-care. The tracking form is two copies of the plain gate network, one per rail. It takes nothing from the plain network. AND and OR act rail by rail. An inversion swaps the two rails and complements them, so the untrusted code maps back onto itself.

When every input is trusted, both rails must match the plain result. That gives three copies of the same value, and a voter takes their 2-of-3 majority and flags any disagreement as a fault. When some input is untrusted, the plain copy is set aside. If the two rails differ, the output could be steered by untrusted data and is reported as untrusted. If the rails agree, the untrusted inputs are masked and the rail value is reported as trusted. The illegal pair code raises an encoding error. A parameter sets the number of independent lanes, and every result is registered.

Top module: `taint_vote_top`

## Requirements
- R1: A synchronous active-high reset clears every lane's `val_o`, `trust_o`, `fault_o` and `enc_err_o` to 0 at the next rising edge. They stay 0 while reset is held.
- R2: Input k of lane L occupies `lab_i[L*2*NIN + 2k +: 2]` as `{hi, lo}`. Its plain bit is `data_i[L*NIN + k]`. Pair 00 is trusted 0, 11 is trusted 1, 01 is untrusted and 10 is illegal. The function is y = NOT( OR over p of (x[2p] AND x[2p+1]) ).
- R3: With all inputs of a lane trusted and no injection, the lane reports `trust_o`=1, `fault_o`=0 and `val_o` equal to the function of the trusted values.
- R4: If untrusted inputs can change the function's result, the lane reports `trust_o`=0 and `val_o`=0.
- R5: If the result does not depend on any untrusted input, the lane reports `trust_o`=1 and `val_o` equal to that fixed result.
- R6: With all inputs trusted, inverting any one of the three copies through `inj_i[L*3 +: 3]` leaves `val_o` correct and raises `fault_o`. Bit 2 of that field inverts the plain copy, bit 1 the hi rail and bit 0 the lo rail.
- R7: When any input of a lane is untrusted, `fault_o` stays 0, and the plain copy (data bits, including an injected plain flip) has no effect on that lane's outputs.
- R8: Any input pair of 10 sets `enc_err_o`=1 and forces `val_o`, `trust_o` and `fault_o` to 0.
- R9: Lanes are independent. One lane's inputs do not change another lane's outputs.
- R10: Outputs change only at a rising clock edge, one cycle after the inputs that cause them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| data_i | input | LANES*NIN | Plain data bits for each lane |
| lab_i | input | LANES*2*NIN | Dual-rail symbols, one `{hi, lo}` pair per input |
| inj_i | input | LANES*3 | Per-lane copy inversion: {plain, hi rail, lo rail} |
| val_o | output | LANES | Voted or rail result value |
| trust_o | output | LANES | 1 when the result is trusted |
| fault_o | output | LANES | 1 when the three copies disagree on trusted inputs |
| enc_err_o | output | LANES | 1 when an input carries the illegal pair code |

## Verification
The hardest case to reach is a disagreement among the three copies while every input is trusted. With correct logic this never happens, so the bench produces it by driving the per-lane inversion field on one copy at a time and expecting the majority to hide the flip while the fault flag rises. The masked-untrusted case is also narrow: an untrusted input paired with a trusted zero, or sitting beside a pair that already forces the OR high. The bench reaches it by walking all 81 three-symbol combinations per lane with both settings of the untrusted data bits. Each outcome is compared with a brute-force model that enumerates every value the untrusted bits could take.

// File: rtl/taint_pkg.sv
package taint_pkg;
  typedef logic [1:0] dr_t;

  localparam dr_t DR_T0  = 2'b00;
  localparam dr_t DR_T1  = 2'b11;
  localparam dr_t DR_U   = 2'b01;
  localparam dr_t DR_BAD = 2'b10;

  function automatic dr_t dr_and(input dr_t a, input dr_t b);
    return {a[1] & b[1], a[0] & b[0]};
  endfunction

  function automatic dr_t dr_or(input dr_t a, input dr_t b);
    return {a[1] | b[1], a[0] | b[0]};
  endfunction

  // swap and complement keeps 01 on 01
  function automatic dr_t dr_not(input dr_t a);
    return {~a[0], ~a[1]};
  endfunction
endpackage

// File: rtl/taint_aoi_rails.sv
module taint_aoi_rails
  import taint_pkg::*;
#(
  parameter int NIN = 4
) (
  input  logic [2*NIN-1:0] lab_i,
  output dr_t              y_o
);
  localparam int NP = NIN / 2;

  dr_t prod [NP];
  dr_t acc;

  for (genvar p = 0; p < NP; p++) begin : g_pair
    assign prod[p] = dr_and(lab_i[4*p +: 2], lab_i[4*p+2 +: 2]);
  end

  always_comb begin
    acc = DR_T0;
    for (int p = 0; p < NP; p++) acc = dr_or(acc, prod[p]);
  end

  assign y_o = dr_not(acc);
endmodule

// File: rtl/taint_aoi_plain.sv
module taint_aoi_plain #(
  parameter int NIN = 4
) (
  input  logic [NIN-1:0] d_i,
  output logic           y_o
);
  localparam int NP = NIN / 2;

  logic [NP-1:0] prod;

  for (genvar p = 0; p < NP; p++) begin : g_pair
    assign prod[p] = d_i[2*p] & d_i[2*p+1];
  end

  assign y_o = ~(|prod);
endmodule

// File: rtl/taint_lane_vote.sv
module taint_lane_vote
  import taint_pkg::*;
#(
  parameter int NIN = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [2*NIN-1:0] lab_i,
  input  logic             plain_i,
  input  dr_t              rail_i,
  input  logic [2:0]       inj_i,
  output logic             val_o,
  output logic             trust_o,
  output logic             fault_o,
  output logic             enc_err_o
);
  logic any_bad, any_unt;
  logic cp, ch, cl;
  logic n_val, n_trust, n_fault, n_enc;

  always_comb begin
    any_bad = 1'b0;
    any_unt = 1'b0;
    for (int k = 0; k < NIN; k++) begin
      if (lab_i[2*k +: 2] == DR_BAD) any_bad = 1'b1;
      if (lab_i[2*k +: 2] == DR_U)   any_unt = 1'b1;
    end
  end

  assign cp = plain_i   ^ inj_i[2];
  assign ch = rail_i[1] ^ inj_i[1];
  assign cl = rail_i[0] ^ inj_i[0];

  always_comb begin
    n_val = 1'b0; n_trust = 1'b0; n_fault = 1'b0; n_enc = 1'b0;
    if (any_bad) begin
      n_enc = 1'b1;
    end else if (!any_unt) begin
      n_trust = 1'b1;
      n_val   = (cp & ch) | (cp & cl) | (ch & cl);
      n_fault = !((cp == ch) && (ch == cl));
    end else if (ch == cl) begin
      n_trust = 1'b1;
      n_val   = ch;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      val_o <= 1'b0; trust_o <= 1'b0; fault_o <= 1'b0; enc_err_o <= 1'b0;
    end else begin
      val_o <= n_val; trust_o <= n_trust; fault_o <= n_fault; enc_err_o <= n_enc;
    end
  end

  AST_ENC_QUIET: assert property (@(posedge clk) disable iff (rst)
    enc_err_o |-> (!val_o && !trust_o && !fault_o)); // R8
  AST_FAULT_TRUSTED: assert property (@(posedge clk) disable iff (rst)
    fault_o |-> trust_o); // R6
  AST_UNTRUST_ZERO: assert property (@(posedge clk) disable iff (rst)
    !trust_o |-> !val_o); // R4
  AST_RAILS_AGREE: assert property (@(posedge clk) disable iff (rst)
    (!any_bad && !any_unt) |-> (rail_i[1] == rail_i[0])); // R3
  AST_CLEAN_NOFAULT: assert property (@(posedge clk) disable iff (rst)
    (!any_bad && !any_unt && inj_i == 3'b000) |=> !fault_o); // R3
  AST_UNT_NOFAULT: assert property (@(posedge clk) disable iff (rst)
    (any_unt && !any_bad) |=> !fault_o); // R7
endmodule

// File: rtl/taint_vote_top.sv
module taint_vote_top
  import taint_pkg::*;
#(
  parameter int LANES = 2,
  parameter int NIN   = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [LANES*NIN-1:0]   data_i,
  input  logic [LANES*2*NIN-1:0] lab_i,
  input  logic [LANES*3-1:0]     inj_i,
  output logic [LANES-1:0]       val_o,
  output logic [LANES-1:0]       trust_o,
  output logic [LANES-1:0]       fault_o,
  output logic [LANES-1:0]       enc_err_o
);
  localparam int LW = 2 * NIN;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic plain_y;
    dr_t  rail_y;

    taint_aoi_plain #(.NIN(NIN)) u_plain (
      .d_i (data_i[l*NIN +: NIN]),
      .y_o (plain_y)
    );

    taint_aoi_rails #(.NIN(NIN)) u_rails (
      .lab_i (lab_i[l*LW +: LW]),
      .y_o   (rail_y)
    );

    taint_lane_vote #(.NIN(NIN)) u_vote (
      .clk       (clk),
      .rst       (rst),
      .lab_i     (lab_i[l*LW +: LW]),
      .plain_i   (plain_y),
      .rail_i    (rail_y),
      .inj_i     (inj_i[l*3 +: 3]),
      .val_o     (val_o[l]),
      .trust_o   (trust_o[l]),
      .fault_o   (fault_o[l]),
      .enc_err_o (enc_err_o[l])
    );
  end
endmodule

// File: tb/sim_taint_vote_top.sv
`timescale 1ns/1ps
module sim_taint_vote_top;
  localparam int LANES = 2;
  localparam int NIN   = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  data_i = '0;
  logic [15:0] lab_i  = '0;
  logic [5:0]  inj_i  = '0;
  logic [1:0]  val_o, trust_o, fault_o, enc_err_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  taint_vote_top #(.LANES(LANES), .NIN(NIN)) u0 (
    .clk(clk), .rst(rst), .data_i(data_i), .lab_i(lab_i), .inj_i(inj_i),
    .val_o(val_o), .trust_o(trust_o), .fault_o(fault_o), .enc_err_o(enc_err_o)
  );

  // {lab[7:0], data[3:0], inj[2:0], val, trust, fault, enc}
  localparam int NV = 8;
  localparam logic [18:0] VEC [NV] = '{
    {8'hFF, 4'hF, 3'b100, 4'b0110},  // R6 plain flip
    {8'hFF, 4'hF, 3'b010, 4'b0110},  // R6 hi rail flip
    {8'h00, 4'h0, 3'b001, 4'b1110},  // R6 lo rail flip
    {8'h00, 4'h0, 3'b000, 4'b1100},  // R3 clean
    {8'h01, 4'h1, 3'b100, 4'b1100},  // R7 plain ignored, masked
    {8'h0D, 4'h3, 3'b000, 4'b0000},  // R4 untrusted reaches output
    {8'h02, 4'h0, 3'b000, 4'b0001},  // R8 illegal on input 0
    {8'h80, 4'h0, 3'b000, 4'b0001}   // R8 illegal on input 3
  };

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  function automatic logic aoi(input logic [3:0] x);
    return ~((x[0] & x[1]) | (x[2] & x[3]));
  endfunction

  // brute force over all values the untrusted inputs could hold
  function automatic void ref_eval(input logic [7:0] lab, output logic v, output logic t);
    logic [3:0] um, tv;
    bit s0, s1;
    s0 = 0; s1 = 0;
    for (int k = 0; k < 4; k++) begin
      um[k] = (lab[2*k +: 2] == 2'b01);
      tv[k] = lab[2*k+1];
    end
    for (int m = 0; m < 16; m++) begin
      if ((4'(m) & ~um) == 4'h0) begin
        if (aoi((tv & ~um) | 4'(m))) s1 = 1; else s0 = 1;
      end
    end
    t = !(s0 && s1);
    v = t ? s1 : 1'b0;
  endfunction

  function automatic void build(input int combo, input bit upass,
                                output logic [7:0] lab, output logic [3:0] d);
    int c;
    c = combo;
    for (int k = 0; k < 4; k++) begin
      case (c % 3)
        0: begin lab[2*k +: 2] = 2'b00; d[k] = 1'b0;  end
        1: begin lab[2*k +: 2] = 2'b11; d[k] = 1'b1;  end
        default: begin lab[2*k +: 2] = 2'b01; d[k] = upass; end
      endcase
      c = c / 3;
    end
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [7:0] la, lb;
    logic [3:0] da, db;
    logic ev, et;

    // R1 reset with live inputs
    lab_i = 16'hFFFF; data_i = 8'hFF;
    repeat (3) @(negedge clk);
    for (int l = 0; l < 2; l++) begin
      chk("R1 val",   val_o[l],     1'b0);
      chk("R1 trust", trust_o[l],   1'b0);
      chk("R1 fault", fault_o[l],   1'b0);
      chk("R1 enc",   enc_err_o[l], 1'b0);
    end
    rst = 1'b0;
    lab_i = 16'h0000; data_i = 8'h00;
    @(negedge clk);

    // R2 R3 R4 R5 R9: exhaustive sweep, lane 1 walks the reverse order
    for (int c = 0; c < 81; c++) begin
      for (int u = 0; u < 2; u++) begin
        build(c, u[0], la, da);
        build(80 - c, ~u[0], lb, db);
        lab_i = {lb, la}; data_i = {db, da}; inj_i = '0;
        @(negedge clk);
        ref_eval(la, ev, et);
        chk("R2 R3 R4 R5 lane0 val",   val_o[0],   ev);
        chk("R2 R3 R4 R5 lane0 trust", trust_o[0], et);
        chk("R3 R7 lane0 fault",       fault_o[0], 1'b0);
        ref_eval(lb, ev, et);
        chk("R9 lane1 val",   val_o[1],   ev);
        chk("R9 lane1 trust", trust_o[1], et);
      end
    end

    // R6 R7 R8 directed table on lane 0, lane 1 held at trusted zeros
    for (int i = 0; i < NV; i++) begin
      lab_i = {8'h00, VEC[i][18:11]};
      data_i = {4'h0, VEC[i][10:7]};
      inj_i = {3'b000, VEC[i][6:4]};
      @(negedge clk);
      chk("R6 R7 R8 table val",   val_o[0],     VEC[i][3]);
      chk("R6 R7 R8 table trust", trust_o[0],   VEC[i][2]);
      chk("R6 R7 table fault",    fault_o[0],   VEC[i][1]);
      chk("R8 table enc",         enc_err_o[0], VEC[i][0]);
      chk("R9 lane1 val",   val_o[1],     1'b1);
      chk("R9 lane1 enc",   enc_err_o[1], 1'b0);
    end

    // R10 latency: outputs hold until the next edge
    lab_i = 16'h0000; data_i = 8'h00; inj_i = '0;
    @(negedge clk);
    lab_i = 16'hFFFF; data_i = 8'hFF;
    #1;
    chk("R10 held before edge", val_o[0], 1'b1);
    @(negedge clk);
    chk("R10 updated after edge", val_o[0], 1'b0);

    // R1 reset mid-run
    lab_i = 16'h0000; data_i = 8'h00;
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk("R1 mid val",   val_o[0],   1'b0);
    chk("R1 mid trust", trust_o[1], 1'b0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 release trust", trust_o[0], 1'b1);

    finish_run();
  end
endmodule